// File: doc/BRIEF.md
# Timer break and output-enable guard

This block is the protection stage of a motor-control timer. A single control word, written over a plain write port, carries the break enable, the break polarity, the main output enable, the automatic re-enable, a digital filter setting that is only stored and passed on to the upstream filter, and a two-bit lock level. The filtered break line and the timer's update-event pulse arrive as inputs. The block gates the normal and complementary channel outputs. Each output either passes its PWM level or is forced to its idle level.

An active break clears main output enable immediately, without waiting for a clock edge. It also sets a sticky break flag that software clears by writing 1. Once the break has gone away, main output enable comes back through a software write. If automatic re-enable is set, the next update event also brings it back. The lock field takes exactly one write after each reset.

Top module: `brk_guard`

## Requirements
- R1: After reset the lock level, filter, break enable, polarity, automatic enable, main output enable and break flag are all 0, and every output is at its idle level.
- R2: The first write after reset loads the lock field from bits [17:16]. Every later write leaves the lock field unchanged until the next reset.
- R3: A reset opens the lock field again, so any of the four codes (0 = off, 1..3 = levels 1 to 3) can be loaded once more.
- R4: The break line is active when it equals the polarity bit (bit [1]). With polarity 0 the active level is low, and with polarity 1 it is high.
- R5: With break enable (bit [0]) at 0, the break line changes neither main output enable nor the break flag.
- R6: An enabled, active break drives main output enable to 0 within the same clock period, with no clock edge needed.
- R7: While main output enable is 0, every normal output equals its idle level and every complementary output equals its idle level.
- R8: While main output enable is 1, each output passes its PWM level when its own enable bit is 1, and otherwise shows its idle level.
- R9: With automatic enable (bit [5]) at 0, an update event leaves main output enable at 0. A write with bit [4] = 1 sets it at the next clock edge.
- R10: With automatic enable at 1 and no break, an update event sets main output enable at the next clock edge.
- R11: While an enabled break is still active, neither a write with bit [4] = 1 nor an update event can set main output enable.
- R12: An enabled active break at a clock edge sets the sticky break flag. A write with bit [2] = 1 clears the flag once the break is gone. A write with bit [2] = 0 leaves it set.
- R13: The filter setting is taken from bits [11:8] of each write and is shown on its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word |
| brk_in | input | 1 | Filtered break line |
| upd_evt | input | 1 | Timer update-event pulse |
| ch_en | input | NCH | Per-channel normal output enable |
| chn_en | input | NCH | Per-channel complementary output enable |
| pwm_p | input | NCH | Normal PWM levels |
| pwm_n | input | NCH | Complementary PWM levels |
| idle_p | input | NCH | Normal idle levels |
| idle_n | input | NCH | Complementary idle levels |
| out_p | output | NCH | Gated normal outputs |
| out_n | output | NCH | Gated complementary outputs |
| moe_o | output | 1 | Main output enable |
| brk_flag_o | output | 1 | Sticky break flag |
| lock_o | output | 2 | Lock level |
| filt_o | output | 4 | Stored filter setting |
| brk_en_o | output | 1 | Break enable |
| brk_pol_o | output | 1 | Break polarity |
| auto_en_o | output | 1 | Automatic re-enable |

## Verification
The hardest case to reach is a break that is still active while software and an update event both try to restore main output enable. Reaching it needs break enable, the matching polarity and automatic enable all configured, with the break line held at its active level across several writes and an update pulse. The bench builds this up in order, then releases the break and checks that only a later update or write restores the outputs. The asynchronous clear is confirmed by moving the break line just after a clock edge and sampling main output enable before the next edge.

// File: rtl/brk_guard_pkg.sv
package brk_guard_pkg;

    localparam int REG_W       = 32;
    localparam int LOCK_LSB    = 16;
    localparam int LOCK_W      = 2;
    localparam int FILT_LSB    = 8;
    localparam int FILT_W      = 4;
    localparam int AUTO_BIT    = 5;
    localparam int MOE_BIT     = 4;
    localparam int FLAGCLR_BIT = 2;
    localparam int POL_BIT     = 1;
    localparam int BEN_BIT     = 0;

    typedef enum logic [LOCK_W-1:0] {
        LOCK_OFF = 2'd0,
        LOCK_L1  = 2'd1,
        LOCK_L2  = 2'd2,
        LOCK_L3  = 2'd3
    } lock_lvl_e;

    typedef struct packed {
        lock_lvl_e          lock;
        logic [FILT_W-1:0]  filt;
        logic               auto_en;
        logic               brk_pol;
        logic               brk_en;
    } cfg_t;

    typedef struct packed {
        logic wr;
        logic moe_val;
        logic flag_clr;
    } wr_cmd_t;

    localparam cfg_t CFG_RESET = '{lock: LOCK_OFF, filt: '0, auto_en: 1'b0,
                                   brk_pol: 1'b0, brk_en: 1'b0};

    function automatic cfg_t apply_write(input cfg_t cur, input logic [REG_W-1:0] d,
                                         input logic lock_open);
        cfg_t n;
        n         = cur;
        n.filt    = d[FILT_LSB +: FILT_W];
        n.auto_en = d[AUTO_BIT];
        n.brk_pol = d[POL_BIT];
        n.brk_en  = d[BEN_BIT];
        if (lock_open) begin
            n.lock = lock_lvl_e'(d[LOCK_LSB +: LOCK_W]);
        end
        return n;
    endfunction

    function automatic logic brk_active(input cfg_t c, input logic line);
        return c.brk_en && (line == c.brk_pol);
    endfunction

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
    import brk_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg,
    output wr_cmd_t          cmd
);

    logic lock_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_RESET;
            lock_open <= 1'b1;
        end else if (wr_en) begin
            cfg       <= apply_write(cfg, wr_data, lock_open);
            lock_open <= 1'b0;
        end
    end

    always_comb begin
        cmd.wr       = wr_en;
        cmd.moe_val  = wr_data[MOE_BIT];
        cmd.flag_clr = wr_data[FLAGCLR_BIT];
    end

endmodule

// File: rtl/brk_moe_ctrl.sv
module brk_moe_ctrl
    import brk_guard_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    brk_hit,
    input  wr_cmd_t cmd,
    input  logic    upd_evt,
    input  logic    auto_en,
    output logic    moe,
    output logic    brk_flag
);

    logic moe_nxt;
    logic flag_nxt;

    always_comb begin
        moe_nxt = moe;
        if (cmd.wr) begin
            moe_nxt = cmd.moe_val;
        end else if (upd_evt && auto_en) begin
            moe_nxt = 1'b1;
        end
        if (brk_hit) begin
            moe_nxt = 1'b0;
        end
    end

    always_comb begin
        flag_nxt = brk_flag;
        if (cmd.wr && cmd.flag_clr) begin
            flag_nxt = 1'b0;
        end
        if (brk_hit) begin
            flag_nxt = 1'b1;
        end
    end

    // Break clears the enable as soon as it is seen, not at a clock edge.
    always_ff @(posedge clk or posedge brk_hit) begin
        if (brk_hit) begin
            moe <= 1'b0;
        end else if (rst) begin
            moe <= 1'b0;
        end else begin
            moe <= moe_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_flag <= 1'b0;
        end else begin
            brk_flag <= flag_nxt;
        end
    end

endmodule

// File: rtl/brk_out_gate.sv
module brk_out_gate #(
    parameter int NCH = 4
) (
    input  logic           moe,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] chn_en,
    input  logic [NCH-1:0] pwm_p,
    input  logic [NCH-1:0] pwm_n,
    input  logic [NCH-1:0] idle_p,
    input  logic [NCH-1:0] idle_n,
    output logic [NCH-1:0] out_p,
    output logic [NCH-1:0] out_n
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic pass_p;
        logic pass_n;
        assign pass_p   = moe && ch_en[g];
        assign pass_n   = moe && chn_en[g];
        assign out_p[g] = pass_p ? pwm_p[g] : idle_p[g];
        assign out_n[g] = pass_n ? pwm_n[g] : idle_n[g];
    end

endmodule

// File: rtl/brk_guard.sv
module brk_guard
    import brk_guard_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               brk_in,
    input  logic               upd_evt,
    input  logic [NCH-1:0]     ch_en,
    input  logic [NCH-1:0]     chn_en,
    input  logic [NCH-1:0]     pwm_p,
    input  logic [NCH-1:0]     pwm_n,
    input  logic [NCH-1:0]     idle_p,
    input  logic [NCH-1:0]     idle_n,
    output logic [NCH-1:0]     out_p,
    output logic [NCH-1:0]     out_n,
    output logic               moe_o,
    output logic               brk_flag_o,
    output logic [LOCK_W-1:0]  lock_o,
    output logic [FILT_W-1:0]  filt_o,
    output logic               brk_en_o,
    output logic               brk_pol_o,
    output logic               auto_en_o
);

    cfg_t    cfg;
    wr_cmd_t cmd;
    logic    brk_hit;
    logic    moe;
    logic    brk_flag;

    brk_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .cmd     (cmd)
    );

    assign brk_hit = brk_active(cfg, brk_in);

    brk_moe_ctrl u_moe (
        .clk      (clk),
        .rst      (rst),
        .brk_hit  (brk_hit),
        .cmd      (cmd),
        .upd_evt  (upd_evt),
        .auto_en  (cfg.auto_en),
        .moe      (moe),
        .brk_flag (brk_flag)
    );

    brk_out_gate #(.NCH(NCH)) u_gate (
        .moe    (moe),
        .ch_en  (ch_en),
        .chn_en (chn_en),
        .pwm_p  (pwm_p),
        .pwm_n  (pwm_n),
        .idle_p (idle_p),
        .idle_n (idle_n),
        .out_p  (out_p),
        .out_n  (out_n)
    );

    assign moe_o      = moe;
    assign brk_flag_o = brk_flag;
    assign lock_o     = cfg.lock;
    assign filt_o     = cfg.filt;
    assign brk_en_o   = cfg.brk_en;
    assign brk_pol_o  = cfg.brk_pol;
    assign auto_en_o  = cfg.auto_en;

endmodule

// File: rtl/brk_guard_chk.sv
module brk_guard_chk
    import brk_guard_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic               brk_in,
    input logic               upd_evt,
    input logic [NCH-1:0]     ch_en,
    input logic [NCH-1:0]     chn_en,
    input logic [NCH-1:0]     pwm_p,
    input logic [NCH-1:0]     pwm_n,
    input logic [NCH-1:0]     idle_p,
    input logic [NCH-1:0]     idle_n,
    input logic [NCH-1:0]     out_p,
    input logic [NCH-1:0]     out_n,
    input logic               moe_o,
    input logic               brk_flag_o,
    input logic [LOCK_W-1:0]  lock_o,
    input logic [FILT_W-1:0]  filt_o,
    input logic               brk_en_o,
    input logic               brk_pol_o,
    input logic               auto_en_o
);

    logic seen_wr;
    logic act;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_wr <= 1'b0;
        end else if (wr_en) begin
            seen_wr <= 1'b1;
        end
    end

    assign act = brk_en_o && (brk_in == brk_pol_o);

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (seen_wr && wr_en) |=> (lock_o == $past(lock_o))); // R2

    AST_BRK_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        act |-> !moe_o); // R6

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !moe_o |-> (out_p == idle_p && out_n == idle_n)); // R7

    AST_NO_AUTO_SET: assert property (@(posedge clk) disable iff (rst)
        (!moe_o && !wr_en && !auto_en_o) |=> !moe_o); // R9

    AST_AUTO_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_evt && auto_en_o && !wr_en && !act) |=> (moe_o || act)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        act |=> brk_flag_o); // R12

endmodule

bind brk_guard brk_guard_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_brk_guard.sv
module tb_brk_guard;
    import brk_guard_pkg::*;

    localparam int CLK_P = 10;
    localparam int NCH   = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic             brk_in = 1'b0;
    logic             upd_evt = 1'b0;
    logic [NCH-1:0]   ch_en  = 4'b0110;
    logic [NCH-1:0]   chn_en = 4'b1001;
    logic [NCH-1:0]   pwm_p  = 4'b1100;
    logic [NCH-1:0]   pwm_n  = 4'b0011;
    logic [NCH-1:0]   idle_p = 4'b1010;
    logic [NCH-1:0]   idle_n = 4'b0101;
    logic [NCH-1:0]   out_p, out_n;
    logic             moe_o, brk_flag_o, brk_en_o, brk_pol_o, auto_en_o;
    logic [1:0]       lock_o;
    logic [3:0]       filt_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    brk_guard #(.NCH(NCH)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t sb[$];

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            0: return {6'd0, lock_o};
            1: return {7'd0, moe_o};
            2: return {7'd0, brk_flag_o};
            3: return {4'd0, out_p};
            4: return {4'd0, out_n};
            5: return {4'd0, filt_o};
            default: return {5'd0, auto_en_o, brk_pol_o, brk_en_o};
        endcase
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = observe(it.sel);
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input logic [7:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [REG_W-1:0] word(input logic [1:0] lk, input logic [3:0] fl,
                                              input logic ae, input logic me,
                                              input logic fc, input logic pl, input logic be);
        logic [REG_W-1:0] w;
        w = '0;
        w[17:16] = lk; w[11:8] = fl; w[5] = ae; w[4] = me;
        w[2] = fc; w[1] = pl; w[0] = be;
        return w;
    endfunction

    task automatic wr(input logic [REG_W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic upd();
        upd_evt = 1'b1;
        tick();
        upd_evt = 1'b0;
    endtask

    function automatic logic [7:0] gate_p();
        return {4'd0, (pwm_p & ch_en) | (idle_p & ~ch_en)};
    endfunction

    function automatic logic [7:0] gate_n();
        return {4'd0, (pwm_n & chn_en) | (idle_n & ~chn_en)};
    endfunction

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        expect_val("R1", 0, 8'd0);
        expect_val("R1", 1, 8'd0);
        expect_val("R1", 2, 8'd0);
        expect_val("R1", 3, {4'd0, idle_p});
        expect_val("R1", 4, {4'd0, idle_n});
        expect_val("R1", 6, 8'd0);
        settle();

        // R2 / R13 / R8 first write
        wr(word(2'd2, 4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        expect_val("R2", 0, 8'd2);
        expect_val("R13", 5, 8'd5);
        expect_val("R8", 1, 8'd1);
        expect_val("R8", 3, gate_p());
        expect_val("R8", 4, gate_n());
        settle();

        // R2 later write ignored for lock; R13 filter still follows
        wr(word(2'd1, 4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        expect_val("R2", 0, 8'd2);
        expect_val("R13", 5, 8'd9);
        settle();

        // R5 break disabled: line toggles have no effect
        brk_in = 1'b1; tick();
        brk_in = 1'b0; tick();
        expect_val("R5", 1, 8'd1);
        expect_val("R5", 2, 8'd0);
        settle();

        // R4/R6 polarity high, async clear
        wr(word(2'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        expect_val("R4", 1, 8'd1);
        expect_val("R4", 6, 8'b011);
        settle();
        @(posedge clk); #1;
        brk_in = 1'b1;
        #1;
        expect_val("R6", 1, 8'd0);
        expect_val("R7", 3, {4'd0, idle_p});
        expect_val("R7", 4, {4'd0, idle_n});
        settle();
        expect_val("R12", 2, 8'd1);
        settle();

        // R11 break still active: write and update cannot set enable
        wr(word(2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1));
        expect_val("R11", 1, 8'd0);
        settle();
        upd();
        expect_val("R11", 1, 8'd0);
        settle();

        // R12 flag stays on write of 0, clears on write of 1
        brk_in = 1'b0;
        wr(word(2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        expect_val("R12", 2, 8'd1);
        settle();
        wr(word(2'd0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1));
        expect_val("R12", 2, 8'd0);
        settle();

        // R9 no automatic set; software write sets
        upd();
        expect_val("R9", 1, 8'd0);
        settle();
        wr(word(2'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        expect_val("R9", 1, 8'd1);
        settle();

        // R10 automatic set on update
        wr(word(2'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
        expect_val("R10", 1, 8'd0);
        settle();
        upd();
        expect_val("R10", 1, 8'd1);
        settle();

        // R4 polarity low
        wr(word(2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        brk_in = 1'b1; tick();
        wr(word(2'd0, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
        expect_val("R4", 1, 8'd1);
        expect_val("R4", 2, 8'd0);
        settle();
        @(posedge clk); #1;
        brk_in = 1'b0;
        #1;
        expect_val("R4", 1, 8'd0);
        settle();
        brk_in = 1'b1; tick();
        upd();
        expect_val("R10", 1, 8'd1);
        settle();

        // R3 reset reopens lock
        rst = 1'b1; tick(); rst = 1'b0;
        expect_val("R1", 0, 8'd0);
        settle();
        wr(word(2'd3, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        expect_val("R3", 0, 8'd3);
        settle();
        wr(word(2'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        expect_val("R3", 0, 8'd3);
        settle();

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule